// File: doc/BRIEF.md
# Pipelined Row Reduction Scheduler

This block sums rows of integers of any length with a single pipelined adder that accepts one operand pair per cycle. Each input word carries a row tag and a flag marking the last word of its row, and words arrive at most one per cycle. Words wait in an input queue whose two oldest entries are visible. Sums leave the adder after a fixed number of stages. A sum that cannot be combined at once is parked in a small store with one slot per tag.

Every cycle a fixed priority picks what enters the adder. First come the adder output and a parked value with the same tag. Next come the adder output and the oldest queued word. After that come the two oldest queued words when their tags match, and then the oldest word paired with zero. If none of these applies, the adder is left idle for that cycle. A per-tag count of live values detects when a closed row has shrunk to one value. The finished sum is then emitted with its tag, with rows in the order their last words arrived. The surrounding system hands out the tags. A tag must not be reused until its result has appeared.

Top module: `pipelined_row_reducer`

## Requirements
- R1: While reset is high, and in the cycles after it until a row completes, out_valid is 0.
- R2: Each emitted out_sum equals the sum of all words of its row, modulo 2^DATA_W.
- R3: Results appear in the order in which the rows' last words (in_last = 1) were accepted, and out_tag carries the row's tag, also when words of different rows are interleaved.
- R4: A row of one word is emitted with that word unchanged: a lone queued word whose row is closed enters the adder paired with the value 0.
- R5: For a row sent to an idle block, out_valid is high exactly DEPTH+2 cycles after the clock edge that accepts the row's last word, and low in the cycles around it.
- R6: Each row produces exactly one result, and out_valid is high for one cycle for it.
- R7: A tag may be used again for a new row once its previous result has been emitted, and the new row's sum does not include any value from the old row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input word is present this cycle |
| in_tag | input | TAG_W | Row tag of the input word |
| in_data | input | DATA_W | Input word value |
| in_last | input | 1 | The word is the last of its row |
| out_valid | output | 1 | A finished row sum is presented |
| out_tag | output | TAG_W | Tag of the finished row |
| out_sum | output | DATA_W | Row sum, wrapped to DATA_W bits |

## Verification
When the block is idle, a result follows at a fixed delay. The edge that accepts the last word makes the row visible in the queue. One edge later the pair enters the adder, and DEPTH-1 further edges bring it to the adder output. The next edge parks it, and the edge after that registers the result, so out_valid rises DEPTH+2 edges after the last word. The latency checks count these negative edges exactly and expect out_valid high only at that count. When rows follow each other without gaps, the exact cycle depends on the scheduling. In that case a monitor compares each pulse with the queue of expected tags and sums, and a final count confirms that there is one result per row.

// File: rtl/pipelined_row_reducer.sv
module pipelined_row_reducer #(
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int DEPTH    = 4,
  parameter int IN_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_sum
);
  localparam int NTAG  = 1 << TAG_W;
  localparam int PW    = $clog2(IN_DEPTH);
  localparam int CNT_W = $clog2(IN_DEPTH + DEPTH + 2) + 1;

  typedef enum logic [2:0] {R_IDLE, R_PS, R_PF, R_FF, R_FZ} rule_e;

  // input queue
  logic [DATA_W-1:0] fq_d [IN_DEPTH];
  logic [TAG_W-1:0]  fq_t [IN_DEPTH];
  logic [PW-1:0]     rd, wr;
  logic [PW:0]       fcnt;

  // adder pipeline
  logic              p_v [DEPTH];
  logic [TAG_W-1:0]  p_t [DEPTH];
  logic [DATA_W-1:0] p_d [DEPTH];

  // parked partial sums and row bookkeeping
  logic              s_v [NTAG];
  logic [DATA_W-1:0] s_d [NTAG];
  logic              closed [NTAG];
  logic [CNT_W-1:0]  cnt [NTAG];

  // completion order
  logic [TAG_W-1:0]  oq [NTAG];
  logic [TAG_W-1:0]  o_rd, o_wr;
  logic [TAG_W:0]    o_cnt;

  wire [DATA_W-1:0] h1_d = fq_d[rd];
  wire [TAG_W-1:0]  h1_t = fq_t[rd];
  wire [DATA_W-1:0] h2_d = fq_d[rd + PW'(1)];
  wire [TAG_W-1:0]  h2_t = fq_t[rd + PW'(1)];
  wire              pv   = p_v[DEPTH-1];
  wire [TAG_W-1:0]  pt   = p_t[DEPTH-1];
  wire [DATA_W-1:0] pd   = p_d[DEPTH-1];
  wire [TAG_W-1:0]  oh   = oq[o_rd];

  rule_e             rule;
  logic [DATA_W-1:0] op_a, op_b;
  logic [TAG_W-1:0]  op_t;
  logic [1:0]        pop;

  always_comb begin
    rule = R_IDLE;
    op_a = '0;
    op_b = '0;
    op_t = h1_t;
    pop  = 2'd0;
    if (pv && s_v[pt]) begin
      rule = R_PS; op_a = pd; op_b = s_d[pt]; op_t = pt;
    end else if (pv && fcnt != 0 && h1_t == pt) begin
      rule = R_PF; op_a = pd; op_b = h1_d; op_t = pt; pop = 2'd1;
    end else if (fcnt >= 2 && h1_t == h2_t) begin
      rule = R_FF; op_a = h1_d; op_b = h2_d; pop = 2'd2;
    end else if (fcnt >= 2 || (fcnt == 1 && closed[h1_t])) begin
      rule = R_FZ; op_a = h1_d; pop = 2'd1;
    end
  end

  wire enter = (rule != R_IDLE);
  wire dec   = (rule == R_PS) || (rule == R_PF) || (rule == R_FF);
  wire park  = pv && (rule != R_PS) && (rule != R_PF);
  wire emit  = (o_cnt != 0) && s_v[oh] && closed[oh] && (cnt[oh] == CNT_W'(1));
  wire close_in = in_valid && in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd <= '0; wr <= '0; fcnt <= '0;
      o_rd <= '0; o_wr <= '0; o_cnt <= '0;
      out_valid <= 1'b0; out_tag <= '0; out_sum <= '0;
      for (int i = 0; i < DEPTH; i++) p_v[i] <= 1'b0;
      for (int t = 0; t < NTAG; t++) begin
        s_v[t] <= 1'b0; closed[t] <= 1'b0; cnt[t] <= '0;
      end
    end else begin
      if (in_valid) begin
        fq_d[wr] <= in_data;
        fq_t[wr] <= in_tag;
        wr <= wr + PW'(1);
      end
      rd   <= rd + PW'(pop);
      fcnt <= fcnt + (PW+1)'(in_valid) - (PW+1)'(pop);

      p_v[0] <= enter;
      p_t[0] <= op_t;
      p_d[0] <= op_a + op_b;
      for (int i = 1; i < DEPTH; i++) begin
        p_v[i] <= p_v[i-1];
        p_t[i] <= p_t[i-1];
        p_d[i] <= p_d[i-1];
      end

      for (int t = 0; t < NTAG; t++) begin
        if (rule == R_PS && pt == TAG_W'(t)) s_v[t] <= 1'b0;
        if (park && pt == TAG_W'(t)) begin
          s_v[t] <= 1'b1;
          s_d[t] <= pd;
        end
        if (emit && oh == TAG_W'(t)) begin
          s_v[t]    <= 1'b0;
          closed[t] <= 1'b0;
          cnt[t]    <= '0;
        end else begin
          cnt[t] <= cnt[t] + CNT_W'(in_valid && in_tag == TAG_W'(t))
                           - CNT_W'(dec && op_t == TAG_W'(t));
          if (close_in && in_tag == TAG_W'(t)) closed[t] <= 1'b1;
        end
      end

      if (close_in) begin
        oq[o_wr] <= in_tag;
        o_wr <= o_wr + TAG_W'(1);
      end
      if (emit) o_rd <= o_rd + TAG_W'(1);
      o_cnt <= o_cnt + (TAG_W+1)'(close_in) - (TAG_W+1)'(emit);

      out_valid <= emit;
      out_tag   <= oh;
      out_sum   <= s_d[oh];
    end
  end

  assert_out_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (fcnt < (PW+1)'(IN_DEPTH) || pop != 0));

  assert_pair_count_R2: assert property (@(posedge clk) disable iff (rst)
    (rule == R_FF) |-> cnt[op_t] >= CNT_W'(2));

  assert_finished_row_alone_R3: assert property (@(posedge clk) disable iff (rst)
    emit |-> !(pv && pt == oh));

  assert_lone_word_identity_R4: assert property (@(posedge clk) disable iff (rst)
    (fcnt == 1 && closed[h1_t] && !pv) |=> (p_v[0] && p_d[0] == $past(h1_d)));
endmodule

// File: tb/sim_pipelined_row_reducer.sv
module sim_pipelined_row_reducer;
  localparam int DW = 16, TW = 3, LAT = 4, QD = 16;
  localparam int NROW = 6;
  localparam int ROW_TAG [NROW] = '{2, 5, 0, 7, 3, 1};
  localparam int ROW_LEN [NROW] = '{3, 1, 5, 2, 7, 4};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [TW-1:0] out_tag;
  logic [DW-1:0] out_sum;

  always #2.5 clk = ~clk;

  pipelined_row_reducer #(.DATA_W(DW), .TAG_W(TW), .DEPTH(LAT), .IN_DEPTH(QD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_tag(out_tag), .out_sum(out_sum));

  int total = 0, bad = 0;
  int exp_t [64];
  int exp_s [64];
  int n_exp = 0, n_got = 0;

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] elem(input int r, input int k);
    return (r == 4) ? 16'hF000 + 16'(k) : 16'(r * 37 + k * 11 + 1);
  endfunction

  task automatic add_exp(input int t, input int s);
    exp_t[n_exp] = t;
    exp_s[n_exp] = s;
    n_exp++;
  endtask

  task automatic send(input int t, input int d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_tag = TW'(t); in_data = DW'(d); in_last = last;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && n_got < n_exp; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (n_got < n_exp) begin
        chk("R3 tag order", int'(out_tag) == exp_t[n_got], int'(out_tag), exp_t[n_got]);
        chk("R2 row sum", int'(out_sum) == exp_s[n_got], int'(out_sum), exp_s[n_got]);
      end else begin
        chk("R6 extra result", 1'b0, n_got + 1, n_exp);
      end
      n_got++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_got, n_exp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sum;
    repeat (3) @(negedge clk);
    chk("R1 reset quiet", out_valid == 1'b0, int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 after reset", out_valid == 1'b0, int'(out_valid), 0);
    end

    // table of rows, back to back
    for (int r = 0; r < NROW; r++) begin
      sum = 0;
      for (int k = 0; k < ROW_LEN[r]; k++) begin
        send(ROW_TAG[r], int'(elem(r, k)), k == ROW_LEN[r] - 1);
        sum = (sum + int'(elem(r, k))) & 16'hFFFF;
      end
      add_exp(ROW_TAG[r], sum);
    end
    idle();
    drain();
    chk("R6 one result per row", n_got == NROW, n_got, NROW);

    // R5: exact latency of a two-word row on an idle block
    send(6, 10, 1'b0);
    send(6, 20, 1'b1);
    add_exp(6, 30);
    idle();
    chk("R5 early", out_valid == 1'b0, int'(out_valid), 0);
    for (int k = 1; k <= LAT + 4; k++) begin
      @(negedge clk);
      chk("R5 latency", out_valid == (k == LAT + 2), int'(out_valid), int'(k == LAT + 2));
    end

    // R4: single-word row passes through unchanged with the same latency
    send(4, 16'hABCD, 1'b1);
    add_exp(4, 16'hABCD);
    idle();
    for (int k = 1; k <= LAT + 4; k++) begin
      @(negedge clk);
      chk("R4 single word", out_valid == (k == LAT + 2), int'(out_valid), int'(k == LAT + 2));
    end

    // R3: interleaved rows, order of closing
    send(0, 100, 1'b0);
    send(1, 7, 1'b0);
    send(1, 9, 1'b1);
    add_exp(1, 16);
    send(0, 5, 1'b0);
    send(0, 3, 1'b1);
    add_exp(0, 108);
    idle();
    drain();

    // R7: reuse of a tag after its result
    send(2, 1000, 1'b0);
    send(2, 2000, 1'b0);
    send(2, 3000, 1'b1);
    add_exp(2, 6000);
    idle();
    drain();
    chk("R7 reuse done", n_got == n_exp, n_got, n_exp);
    chk("R6 total results", n_got == NROW + 5, n_got, NROW + 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule